// File: doc/BRIEF.md
# Integer ALU with Registered Status Flags

This block is a 32-bit integer arithmetic and logic unit. Every cycle it combines two operands under a 3-bit operation code and drives the result on `result` without delay. It covers add, add with incoming carry, subtract, subtract with incoming borrow, and the bitwise AND, OR and XOR.

Along with the result it derives six status flags: unsigned carry or borrow, signed overflow, sign, zero, a nibble carry from bit 3 into bit 4, and even parity of the low result byte. The flags are captured into a 6-bit flags word on a rising clock edge, but only in cycles where `upd_en` is high. A surrounding datapath can therefore compute speculatively and commit status only for the operations that should update it.

The operand carry or borrow comes from the `carry_in` port and not from the stored flags word. The datapath decides which value to feed back.

Top module: `alu_status_core`

## Requirements
- R1: Operation codes 0 (add) and 1 (add with carry) give `result` = A + B + (code 1 ? carry_in : 0) modulo 2^32, combinationally in the same cycle.
- R2: Operation codes 2 (subtract) and 3 (subtract with borrow) give `result` = A − B − (code 3 ? carry_in : 0) modulo 2^32, combinationally.
- R3: Flags bit 0 (carry): for add codes it is the carry out of bit 31. For subtract codes it is 1 exactly when unsigned A < B + borrow_in.
- R4: Flags bit 5 (overflow): for add codes it is 1 when A and B share a sign and the result sign differs. For subtract codes it is 1 when A and B differ in sign and the result sign differs from A's.
- R5: Flags bit 4 (sign) equals bit 31 of the result.
- R6: Flags bit 3 (zero) is 1 exactly when the result is all zeros.
- R7: Flags bit 2 (nibble carry): for add codes it is the carry from bit 3 into bit 4. For subtract codes it is 1 when A[3:0] < B[3:0] + borrow_in. It is 0 for every other code.
- R8: Flags bit 1 (parity) is 1 exactly when result bits 7..0 contain an even number of ones.
- R9: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B, with carry, overflow and nibble carry all 0.
- R10: The flags word loads on a rising clock edge only when `upd_en` is high. Otherwise it keeps its value whatever the other inputs do.
- R11: While `rst_n` is low the flags word is all zeros.
- R12: Code 7 is reserved: the result is 0, and the flags follow the logical-operation rules (zero = 1, parity = 1, others 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags word |
| upd_en | input | 1 | Commit strobe for the flags word |
| op_code | input | 3 | Operation select (0 add, 1 adc, 2 sub, 3 sbb, 4 and, 5 or, 6 xor, 7 reserved) |
| opnd_a | input | 32 | First operand / minuend |
| opnd_b | input | 32 | Second operand / subtrahend |
| carry_in | input | 1 | Incoming carry (code 1) or borrow (code 3) |
| result | output | 32 | Combinational result |
| flags_q | output | 6 | Registered flags {overflow, sign, zero, nibble carry, parity, carry} |

## Verification
The clocked properties assume that `op_code`, the operands and `carry_in` are stable and known at each rising edge where `upd_en` is high. They also assume that the flags word seen one cycle later belongs to the operation presented in that cycle. The stimulus respects this by changing every input only on the falling edge and holding it across the next rising edge. `upd_en` is pulsed for exactly one edge per committed operation, and the reserved code is driven only in a dedicated scenario.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_ZERO = 2'd3
    } logic_sel_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic nib;
        logic par;
        logic cry;
    } status_t;

    localparam int STATUS_BITS = $bits(status_t);

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ext_cin,
    input  logic         is_sub,
    input  logic         use_cin,
    output logic [W-1:0] sum,
    output logic         cf,
    output logic         of,
    output logic         af
);
    localparam int LOW = W - 1;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] low_sum;
    logic [1:0]   top_sum;
    logic [4:0]   nib_sum;

    always_comb begin
        b_eff   = is_sub ? ~b : b;
        cin     = is_sub ? ~(use_cin & ext_cin) : (use_cin & ext_cin);
        low_sum = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]} + {{(W-1){1'b0}}, cin};
        top_sum = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, low_sum[W-1]};
        nib_sum = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, cin};
        sum     = {top_sum[0], low_sum[LOW-1:0]};
        cf      = top_sum[1] ^ is_sub;
        of      = top_sum[1] ^ low_sum[W-1];
        af      = nib_sum[4] ^ is_sub;
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_status_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_result_flags.sv
module alu_result_flags #(
    parameter int W     = 32,
    parameter int PBITS = 8
) (
    input  logic [W-1:0] y,
    output logic         sgn,
    output logic         zro,
    output logic         par
);
    always_comb begin
        sgn = y[W-1];
        zro = (y == '0);
        par = ~^y[PBITS-1:0];
    end
endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic [5:0]       flags_q
);
    localparam int MSB = WIDTH - 1;

    alu_op_e      op;
    logic         is_arith;
    logic         is_sub;
    logic         use_cin;
    logic_sel_e   lsel;
    logic [MSB:0] arith_y;
    logic [MSB:0] logic_y;
    logic         a_cf, a_of, a_af;
    logic         r_sgn, r_zro, r_par;
    status_t      next_st;
    status_t      st_q;

    always_comb begin
        op       = alu_op_e'(op_code);
        is_arith = 1'b0;
        is_sub   = 1'b0;
        use_cin  = 1'b0;
        lsel     = LG_ZERO;
        unique case (op)
            OP_ADD:  is_arith = 1'b1;
            OP_ADC:  begin is_arith = 1'b1; use_cin = 1'b1; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_SBB:  begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
            OP_AND:  lsel = LG_AND;
            OP_OR:   lsel = LG_OR;
            OP_XOR:  lsel = LG_XOR;
            default: lsel = LG_ZERO;
        endcase
    end

    alu_addsub #(.W(WIDTH)) u_addsub (
        .a(opnd_a), .b(opnd_b), .ext_cin(carry_in), .is_sub(is_sub),
        .use_cin(use_cin), .sum(arith_y), .cf(a_cf), .of(a_of), .af(a_af)
    );

    alu_logic_unit #(.W(WIDTH)) u_logic (
        .a(opnd_a), .b(opnd_b), .sel(lsel), .y(logic_y)
    );

    assign result = is_arith ? arith_y : logic_y;

    alu_result_flags #(.W(WIDTH), .PBITS(8)) u_rflags (
        .y(result), .sgn(r_sgn), .zro(r_zro), .par(r_par)
    );

    always_comb begin
        next_st.ovf = is_arith & a_of;
        next_st.cry = is_arith & a_cf;
        next_st.nib = is_arith & a_af;
        next_st.sgn = r_sgn;
        next_st.zro = r_zro;
        next_st.par = r_par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st_q <= '0;
        else if (upd_en) st_q <= next_st;
    end

    assign flags_q = st_q;

    // R11: flags word cleared by reset
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> flags_q == 6'd0);

    // R10: no enable, no change
    assert_hold_no_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(flags_q));

    // R6: zero flag tracks committed result
    assert_zero_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags_q[3] == ($past(result) == '0));

    // R5: sign flag tracks committed result
    assert_sign_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags_q[4] == $past(result[MSB]));

    // R9: logical codes leave carry, overflow and nibble carry clear
    assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_code[2]) |=> (flags_q[0] == 1'b0 && flags_q[5] == 1'b0 && flags_q[2] == 1'b0));

    // R3: plain add carries out exactly when A exceeds ~B
    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_code == 3'd0) |=> flags_q[0] == ($past(opnd_a) > ~$past(opnd_b)));

    // R3: plain subtract borrows exactly when A is below B
    assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_code == 3'd2) |=> flags_q[0] == ($past(opnd_a) < $past(opnd_b)));
endmodule

// File: tb/sim_alu_status_core.sv
module sim_alu_status_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic [5:0]  flags_q;

    int total = 0;
    int bad = 0;
    logic [5:0] last_flags = '0;

    always #5 clk = ~clk;

    alu_status_core u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .result(result), .flags_q(flags_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Applies one operation, checks the result, commits the flags and checks them.
    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input logic ci);
        logic [32:0] wide;
        logic [31:0] r;
        logic cf, of, af;
        logic k;
        logic [5:0] ef;
        k = (op == 3'd1 || op == 3'd3) ? ci : 1'b0;
        cf = 1'b0; of = 1'b0; af = 1'b0;
        case (op)
            3'd0, 3'd1: begin
                wide = {1'b0, a} + {1'b0, b} + {32'd0, k};
                r = wide[31:0];
                cf = wide[32];
                af = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, k}) > 5'd15;
                of = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd2, 3'd3: begin
                r = a - b - {31'd0, k};
                cf = {1'b0, a} < ({1'b0, b} + {32'd0, k});
                af = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'd0, k});
                of = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            default: r = 32'd0;
        endcase
        ef = {of, r[31], (r == 32'd0), af, ~^r[7:0], cf};
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; carry_in = ci; upd_en = 1'b1;
        #1;
        if (op <= 3'd1)      check("R1 add result", result, r);
        else if (op <= 3'd3) check("R2 sub result", result, r);
        else if (op <= 3'd6) check("R9 logic result", result, r);
        else                 check("R12 reserved result", result, r);
        @(negedge clk);
        upd_en = 1'b0;
        check("R3 carry",     {31'd0, flags_q[0]}, {31'd0, ef[0]});
        check("R8 parity",    {31'd0, flags_q[1]}, {31'd0, ef[1]});
        check("R7 nibble",    {31'd0, flags_q[2]}, {31'd0, ef[2]});
        check("R6 zero",      {31'd0, flags_q[3]}, {31'd0, ef[3]});
        check("R5 sign",      {31'd0, flags_q[4]}, {31'd0, ef[4]});
        check("R4 overflow",  {31'd0, flags_q[5]}, {31'd0, ef[5]});
        last_flags = flags_q;
    endtask

    task automatic t_reset();
        upd_en = 1'b1; op_code = 3'd7;
        repeat (2) @(negedge clk);
        check("R11 reset flags", {26'd0, flags_q}, 32'd0);
        upd_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 flags after release", {26'd0, flags_q}, 32'd0);
    endtask

    task automatic t_add();
        do_op(3'd0, 32'h0000_0001, 32'h0000_0002, 1'b1);
        do_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        do_op(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
        do_op(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0);
        do_op(3'd0, 32'h0000_000F, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_adc();
        do_op(3'd1, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1);
        do_op(3'd1, 32'h1234_5678, 32'h0FED_CBA8, 1'b1);
        do_op(3'd1, 32'h0000_0007, 32'h0000_0008, 1'b1);
    endtask

    task automatic t_sub();
        do_op(3'd2, 32'h0000_0005, 32'h0000_0005, 1'b1);
        do_op(3'd2, 32'h0000_0003, 32'h0000_0005, 1'b0);
        do_op(3'd2, 32'h8000_0000, 32'h0000_0001, 1'b0);
        do_op(3'd2, 32'h0000_0010, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_sbb();
        do_op(3'd3, 32'h0000_0005, 32'h0000_0005, 1'b1);
        do_op(3'd3, 32'h0000_0000, 32'h0000_0000, 1'b1);
        do_op(3'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_logic();
        do_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // leaves carry/nibble set first
        do_op(3'd4, 32'hF0F0_FFFF, 32'h0FFF_0F0F, 1'b1);
        do_op(3'd5, 32'h8000_0000, 32'h0000_0003, 1'b1);
        do_op(3'd6, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
    endtask

    task automatic t_parity();
        do_op(3'd5, 32'hFFFF_FF00, 32'h0000_0001, 1'b0);
        do_op(3'd5, 32'h0000_0100, 32'h0000_0081, 1'b0);
    endtask

    task automatic t_reserved();
        do_op(3'd7, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
    endtask

    task automatic t_hold();
        do_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        @(negedge clk);
        upd_en = 1'b0; op_code = 3'd0; opnd_a = 32'h4000_0000; opnd_b = 32'h4000_0000; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 hold with enable low", {26'd0, flags_q}, {26'd0, last_flags});
        op_code = 3'd6; opnd_a = 32'h0000_0001;
        repeat (2) @(negedge clk);
        check("R10 hold after input change", {26'd0, flags_q}, {26'd0, last_flags});
    endtask

    initial begin
        t_reset();
        t_add();
        t_adc();
        t_sub();
        t_sbb();
        t_logic();
        t_parity();
        t_reserved();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule